// File: doc/BRIEF.md
# Segmented Thermometer Switch Decoder

This block turns a 14-bit binary sample into the complete set of switch controls for a segmented current-steering converter. The sample is cut into three fields. The top field drives a bank of equal-weight large cells through a thermometer code. The middle field drives a second bank of equal-weight cells, also through a thermometer code. The bottom field drives binary-weighted cells directly, with no decoding.

Thermometer coding means that a step between neighbouring codes turns cells on or off only at the top of a bank. This keeps the step size uniform and reduces glitches. All decoded controls are registered together in one latch, so every switch changes on the same rising edge. The latch supplies a true and an inverted line for each switch, and each of the two lines comes from its own flop. A synchronous reset puts the output into the state that represents code 0.

Top module: `segmented_switch_decoder`

## Requirements
- R1: The sample is split as bits [13:9] for the upper bank, bits [8:5] for the middle bank and bits [4:0] for the binary tail.
- R2: Upper-bank line k (31 lines, line 0 lowest) is high exactly when the value of bits [13:9] is greater than k.
- R3: Middle-bank line k (15 lines, line 0 lowest) is high exactly when the value of bits [8:5] is greater than k.
- R4: Binary tail output bit i equals sample bit i, for i from 0 to 4.
- R5: Every output reflects the sample present at the previous rising clock edge. All 51 switch pairs update on that same edge.
- R6: Each inverted output is always the bitwise complement of its true output.
- R7: While rst is high at a rising edge, all true outputs go low and all inverted outputs go high on that edge.
- R8: The weighted sum 512 × (upper lines high) + 32 × (middle lines high) + binary tail value equals the sample from the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_in | input | 14 | Binary input sample |
| upper_on | output | 31 | Upper-bank true switch controls |
| upper_off | output | 31 | Upper-bank inverted switch controls |
| middle_on | output | 15 | Middle-bank true switch controls |
| middle_off | output | 15 | Middle-bank inverted switch controls |
| tail_on | output | 5 | Binary tail true switch controls |
| tail_off | output | 5 | Binary tail inverted switch controls |

## Verification
The bench builds the block with its default 5-4-5 split. This makes the full 14-bit code space reachable, including the bank boundaries at multiples of 32 and 512, the all-zero and all-one codes, and a reset applied in the middle of traffic. Each clock, a behavioural model derives every thermometer line and the weighted sum from the previous sample. The model then compares every true and inverted output against those values.

// File: rtl/seg_dec_pkg.sv
package seg_dec_pkg;
    localparam int UPPER_BITS_DEF  = 5;
    localparam int MIDDLE_BITS_DEF = 4;
    localparam int TAIL_BITS_DEF   = 5;

    function automatic int thermo_lines(input int bits);
        return (1 << bits) - 1;
    endfunction
endpackage

// File: rtl/thermo_decoder.sv
module thermo_decoder #(
    parameter int IN_W = 4,
    localparam int LINES = (1 << IN_W) - 1
) (
    input  logic [IN_W-1:0]  value,
    output logic [LINES-1:0] lines
);
    for (genvar k = 0; k < LINES; k++) begin : g_line
        assign lines[k] = (32'(value) > k);
    end
endmodule

// File: rtl/switch_latch.sv
module switch_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] qn
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q  <= '0;
            qn <= '1;
        end else begin
            q  <= d;
            qn <= ~d;
        end
    end

    p_pair_complement_r6: assert property (@(posedge clk) disable iff (rst)
        qn == ~q);
endmodule

// File: rtl/segmented_switch_decoder.sv
module segmented_switch_decoder
    import seg_dec_pkg::*;
#(
    parameter int UPPER_BITS  = UPPER_BITS_DEF,
    parameter int MIDDLE_BITS = MIDDLE_BITS_DEF,
    parameter int TAIL_BITS   = TAIL_BITS_DEF,
    localparam int CODE_W     = UPPER_BITS + MIDDLE_BITS + TAIL_BITS,
    localparam int UPPER_N    = thermo_lines(UPPER_BITS),
    localparam int MIDDLE_N   = thermo_lines(MIDDLE_BITS),
    localparam int CTRL_W     = UPPER_N + MIDDLE_N + TAIL_BITS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [CODE_W-1:0]    sample_in,
    output logic [UPPER_N-1:0]   upper_on,
    output logic [UPPER_N-1:0]   upper_off,
    output logic [MIDDLE_N-1:0]  middle_on,
    output logic [MIDDLE_N-1:0]  middle_off,
    output logic [TAIL_BITS-1:0] tail_on,
    output logic [TAIL_BITS-1:0] tail_off
);
    localparam int MIDDLE_LSB = TAIL_BITS;

    // R1: field split
    logic [UPPER_BITS-1:0]  upper_field;
    logic [MIDDLE_BITS-1:0] middle_field;
    logic [TAIL_BITS-1:0]   tail_field;
    assign upper_field  = sample_in[CODE_W-1 -: UPPER_BITS];
    assign middle_field = sample_in[MIDDLE_LSB +: MIDDLE_BITS];
    assign tail_field   = sample_in[TAIL_BITS-1:0];

    logic [UPPER_N-1:0]  upper_lines;
    logic [MIDDLE_N-1:0] middle_lines;

    thermo_decoder #(.IN_W(UPPER_BITS)) u_upper_dec (
        .value(upper_field), .lines(upper_lines));
    thermo_decoder #(.IN_W(MIDDLE_BITS)) u_middle_dec (
        .value(middle_field), .lines(middle_lines));

    // R5: one shared latch realigns all switches
    logic [CTRL_W-1:0] ctrl_d, ctrl_q, ctrl_qn;
    assign ctrl_d = {tail_field, middle_lines, upper_lines};

    switch_latch #(.W(CTRL_W)) u_latch (
        .clk(clk), .rst(rst), .d(ctrl_d), .q(ctrl_q), .qn(ctrl_qn));

    assign upper_on   = ctrl_q[UPPER_N-1:0];
    assign upper_off  = ctrl_qn[UPPER_N-1:0];
    assign middle_on  = ctrl_q[UPPER_N +: MIDDLE_N];
    assign middle_off = ctrl_qn[UPPER_N +: MIDDLE_N];
    assign tail_on    = ctrl_q[CTRL_W-1 -: TAIL_BITS];
    assign tail_off   = ctrl_qn[CTRL_W-1 -: TAIL_BITS];

    p_upper_count_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ($countones(upper_on) == 32'($past(sample_in[CODE_W-1 -: UPPER_BITS]))));
    p_middle_count_r3: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ($countones(middle_on) == 32'($past(sample_in[MIDDLE_LSB +: MIDDLE_BITS]))));
    p_tail_pass_r4: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (tail_on == $past(sample_in[TAIL_BITS-1:0])));
    p_upper_shape_r2: assert property (@(posedge clk) disable iff (rst)
        ((upper_on >> 1) & ~upper_on) == '0);
    p_middle_shape_r3: assert property (@(posedge clk) disable iff (rst)
        ((middle_on >> 1) & ~middle_on) == '0);
    p_weighted_sum_r8: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (($countones(upper_on) * (1 << (MIDDLE_BITS + TAIL_BITS))
                        + $countones(middle_on) * (1 << TAIL_BITS)
                        + 32'(tail_on)) == 32'($past(sample_in))));
endmodule

// File: tb/segmented_switch_decoder_tb.sv
module segmented_switch_decoder_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [13:0] sample_in = '0;
    logic [30:0] upper_on, upper_off;
    logic [14:0] middle_on, middle_off;
    logic [4:0]  tail_on, tail_off;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    segmented_switch_decoder u_dut (
        .clk(clk), .rst(rst), .sample_in(sample_in),
        .upper_on(upper_on), .upper_off(upper_off),
        .middle_on(middle_on), .middle_off(middle_off),
        .tail_on(tail_on), .tail_off(tail_off));

    // behavioural reference: what the outputs must show after each edge
    int  ref_code   = 0;
    bit  ref_in_rst = 1'b1;
    always @(posedge clk) begin
        ref_in_rst <= rst;
        ref_code   <= rst ? 0 : int'(sample_in);
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (ref code %0d)", req, act, exp, ref_code);
        end
    endtask

    task automatic compare_all();
        int up_v, mid_v, sum;
        bit up_ok, mid_ok;
        up_v  = (ref_code >> 9) & 31;
        mid_v = (ref_code >> 5) & 15;
        up_ok = 1'b1;
        mid_ok = 1'b1;
        for (int k = 0; k < 31; k++)
            if (upper_on[k] !== (up_v > k)) up_ok = 1'b0;
        for (int k = 0; k < 15; k++)
            if (middle_on[k] !== (mid_v > k)) mid_ok = 1'b0;
        check(up_ok, "R1/R2/R5 upper lines", $countones(upper_on), up_v);
        check(mid_ok, "R1/R3/R5 middle lines", $countones(middle_on), mid_v);
        check(tail_on === 5'(ref_code), "R4/R5 tail bits", int'(tail_on), ref_code & 31);
        check(upper_off === ~upper_on && middle_off === ~middle_on && tail_off === ~tail_on,
              "R6 complement", int'(upper_off[15:0]), int'(~upper_on[15:0]));
        sum = 512 * $countones(upper_on) + 32 * $countones(middle_on) + int'(tail_on);
        check(sum == ref_code, "R8 weighted sum", sum, ref_code);
        if (ref_in_rst)
            check(upper_on == '0 && middle_on == '0 && tail_on == '0 && upper_off == '1
                  && middle_off == '1 && tail_off == '1, "R7 reset state",
                  int'(tail_on), 0);
    endtask

    // compare at every falling edge, before new stimulus is driven
    always @(negedge clk) if (!done) compare_all();

    task automatic apply(input int code);
        @(negedge clk);
        #1 sample_in = 14'(code);
    endtask

    initial begin
        sample_in = 14'h3fff;          // R7: ignored during reset
        repeat (3) @(negedge clk);
        #1 rst = 1'b0;
        apply(0);
        apply(16383);
        apply(0);
        // bank boundaries
        apply(31); apply(32); apply(33); apply(511); apply(512); apply(513);
        apply(8191); apply(8192); apply(16352); apply(16383); apply(1);
        // walking ones
        for (int i = 0; i < 14; i++) apply(1 << i);
        // ramp across several middle and upper boundaries
        for (int c = 0; c < 2048; c += 7) apply(c);
        // mid-traffic reset (R7)
        apply(12345);
        @(negedge clk); #1 rst = 1'b1; sample_in = 14'd9999;
        @(negedge clk); #1 rst = 1'b0;
        apply(4660);
        for (int i = 0; i < 400; i++) apply(int'($urandom_range(0, 16383)));
        apply(0);
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule